// File: doc/BRIEF.md
# Two-Phase Link Training Controller

This block runs the link-training handshake of a multi-lane serial display link against a sink device. It reaches the sink only through a byte-wide register access port (request, write enable, address, write data, acknowledge, read data); the transport that carries those accesses and the analog lane drivers sit outside the block. Software or a sequencer supplies the number of active lanes and a start pulse. The block then reports a uniform drive setting for the four lanes, the training pattern in use, a done flag and a reason code.

A run first reads two capability bytes from the sink and refuses to train on a link-rate code it does not support or on a lane capability of zero. It then runs a clock-recovery phase with pattern 1, followed by a channel-equalisation phase with pattern 2. Every iteration writes the lane setting to the sink, waits a parameterised number of cycles and reads a six-byte status block. After a failed check it adopts the largest swing and the largest pre-emphasis that any active lane requests. On completion the pattern is switched off at the sink and locally.

Top module: `lt_train_ctrl`

## Requirements
- R1: After reset `done`=0, `train_pat`=0, `lane_drive`=0, `fail_code`=0 and `sink_req`=0.
- R2: A start first reads sink bytes 0x001 (rate code) and 0x002 (lane capability, bits 4:0). A rate other than 0x06 or 0x0A, or a lane capability of zero, ends the run with `fail_code`=1 and no sink writes. A `lane_cnt` of 0 is used as 1, and one above 4 as 4.
- R3: Clock recovery begins by writing 1 to sink address 0x102 and showing 1 on `train_pat`, with all lane settings cleared to 0.
- R4: Each iteration writes the setting to sink addresses 0x103+n for every active lane n, waits CR_WAIT+1 cycles (EQ_WAIT+1 in equalisation), then reads six bytes from 0x202..0x207.
- R5: Lane n's status nibble is status byte n>>1, bits (n&1)*4+3:(n&1)*4. Clock recovery passes once nibble bit 0 is set for every active lane; inactive lanes are ignored.
- R6: Clock recovery fails (`fail_code`=2) when a check fails while the current setting already has its max-swing flag set.
- R7: When a failed check finds lane 0's swing equal to its value at the previous iteration, a repeat count rises; the fifth repeat fails clock recovery with code 2. A change of swing clears the count, and the first iteration never counts as a repeat.
- R8: Requests are in status byte 4+(n>>1): swing at bits (n&1)*4+1:(n&1)*4, pre-emphasis at (n&1)*4+3:(n&1)*4+2. The new setting takes the maximum of each over the active lanes and is driven on all four lanes. The setting byte packs swing in bits 1:0, the max-swing flag in bit 2, pre-emphasis in bits 4:3 and the max-pre-emphasis flag in bit 5.
- R9: The max-swing flag is set whenever swing is 3, and the max-pre-emphasis flag whenever pre-emphasis is 3.
- R10: Equalisation writes 2 to 0x102 and runs at most five iterations. It passes only if status byte 2 bit 0 (inter-lane alignment) is set and every active nibble has bits 2:0 all set. After five failures it ends with `fail_code`=3.
- R11: Every run that reaches training writes 0 to 0x102, drives `train_pat` to 0 and raises `done`, with `fail_code`=0 on success. `done` holds until the next start, and no sink request is made while it is high.
- R12: `sink_req` stays high with stable address, direction and data until `sink_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a training run (taken when idle or done) |
| lane_cnt | input | 3 | Number of active lanes, 1 to 4 |
| sink_req | output | 1 | Sink register access request |
| sink_we | output | 1 | 1 = write, 0 = read |
| sink_addr | output | ADDR_W | Sink register address |
| sink_wdata | output | 8 | Write byte |
| sink_ack | input | 1 | Access complete; read byte valid |
| sink_rdata | input | 8 | Read byte |
| train_pat | output | 2 | Local training pattern select (0 off, 1, 2) |
| lane_drive | output | 32 | Four lane setting bytes, lane 0 in bits 7:0 |
| done | output | 1 | Run finished |
| fail_code | output | 2 | 0 pass, 1 capability refused, 2 clock recovery, 3 equalisation |

## Verification
The hardest case to reach from the ports is the repeat-count reset. The sink has to keep clock recovery failing while lane 0's swing first changes and then settles, so that the count is cleared before it climbs to five. The bench's sink model requests a swing one step above what it last received, capped at level 2, and holds lane 0's recovery bit low. This gives two changing iterations and then five repeats, for eight status reads in total. Other sink settings reach the max-swing stop, withhold alignment, and place requests in the upper request byte so that the field positions are exercised.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int LANES_MAX  = 4;
    localparam int STAT_BYTES = 6;
    localparam int STAT_W     = STAT_BYTES * 8;

    // sink register addresses (decoded by the sink)
    localparam int ADR_CAP_RATE = 'h001;
    localparam int ADR_PATTERN  = 'h102;
    localparam int ADR_LANE0    = 'h103;
    localparam int ADR_STATUS   = 'h202;

    localparam logic [7:0] RATE_LOW  = 8'h06;
    localparam logic [7:0] RATE_HIGH = 8'h0A;

    typedef enum logic [1:0] {
        FAIL_NONE   = 2'd0,
        FAIL_CAPS   = 2'd1,
        FAIL_CLKREC = 2'd2,
        FAIL_EQUAL  = 2'd3
    } fail_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       pre_max;
        logic [1:0] pre;
        logic       sw_max;
        logic [1:0] sw;
    } drive_t;

    function automatic logic rate_ok(input logic [7:0] code);
        return (code == RATE_LOW) || (code == RATE_HIGH);
    endfunction

    function automatic logic [2:0] clamp_lanes(input logic [2:0] n);
        if (n == 3'd0)
            return 3'd1;
        else if (n > 3'd4)
            return 3'd4;
        return n;
    endfunction

    function automatic drive_t make_drive(input logic [1:0] sw, input logic [1:0] pre);
        drive_t d;
        d.rsvd    = 2'b00;
        d.sw      = sw;
        d.pre     = pre;
        d.sw_max  = (sw == 2'd3);
        d.pre_max = (pre == 2'd3);
        return d;
    endfunction

endpackage

// File: rtl/lt_xfer.sv
module lt_xfer #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              we,
    input  logic [ADDR_W-1:0] base,
    input  logic [2:0]        len,
    input  logic [7:0]        wdata,
    output logic              fin,
    output logic              rd_strobe,
    output logic [2:0]        rd_idx,
    output logic [7:0]        rd_data,
    output logic              sink_req,
    output logic              sink_we,
    output logic [ADDR_W-1:0] sink_addr,
    output logic [7:0]        sink_wdata,
    input  logic              sink_ack,
    input  logic [7:0]        sink_rdata
);

    logic              active;
    logic [2:0]        idx;
    logic [2:0]        last;
    logic              we_q;
    logic [ADDR_W-1:0] base_q;
    logic [7:0]        wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            last   <= '0;
            we_q   <= 1'b0;
            base_q <= '0;
            wd_q   <= '0;
        end else if (!active && go) begin
            active <= 1'b1;
            idx    <= '0;
            last   <= len - 3'd1;
            we_q   <= we;
            base_q <= base;
            wd_q   <= wdata;
        end else if (active && sink_ack) begin
            if (idx == last)
                active <= 1'b0;
            else
                idx <= idx + 3'd1;
        end
    end

    assign fin        = active && sink_ack && (idx == last);
    assign rd_strobe  = active && sink_ack && !we_q;
    assign rd_idx     = idx;
    assign rd_data    = sink_rdata;
    assign sink_req   = active;
    assign sink_we    = we_q;
    assign sink_addr  = base_q + ADDR_W'(idx);
    assign sink_wdata = wd_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sink_req && !sink_ack) |=> (sink_req && $stable(sink_addr) && $stable(sink_we) && $stable(sink_wdata))) // R12
        else $error("request dropped or changed before acknowledge");

endmodule

// File: rtl/lt_wait.sv
module lt_wait #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] val,
    output logic         fin
);

    logic         running;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (go) begin
            running <= 1'b1;
            cnt     <= val;
        end else if (running) begin
            if (cnt == '0)
                running <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    assign fin = running && (cnt == '0);

endmodule

// File: rtl/lt_eval.sv
module lt_eval
    import lt_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    input  logic [2:0]        lanes,
    output logic              cr_ok,
    output logic              eq_ok,
    output drive_t            nxt
);

    logic [3:0] nib [LANES_MAX];
    logic [3:0] req [LANES_MAX];

    for (genvar n = 0; n < LANES_MAX; n++) begin : g_lane
        assign nib[n] = stat[(n / 2) * 8 + (n % 2) * 4 +: 4];
        assign req[n] = stat[(4 + n / 2) * 8 + (n % 2) * 4 +: 4];
    end

    always_comb begin
        logic [1:0] sw_m;
        logic [1:0] pre_m;
        cr_ok = 1'b1;
        eq_ok = stat[16];
        sw_m  = 2'd0;
        pre_m = 2'd0;
        for (int n = 0; n < LANES_MAX; n++) begin
            if (3'(n) < lanes) begin
                if (!nib[n][0])
                    cr_ok = 1'b0;
                if (nib[n][2:0] != 3'b111)
                    eq_ok = 1'b0;
                if (req[n][1:0] > sw_m)
                    sw_m = req[n][1:0];
                if (req[n][3:2] > pre_m)
                    pre_m = req[n][3:2];
            end
        end
        nxt = make_drive(sw_m, pre_m);
    end

endmodule

// File: rtl/lt_train_ctrl.sv
module lt_train_ctrl
    import lt_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int CR_WAIT  = 200000,
    parameter int EQ_WAIT  = 80000,
    parameter int CR_LIMIT = 5,
    parameter int EQ_LIMIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        lane_cnt,
    output logic              sink_req,
    output logic              sink_we,
    output logic [ADDR_W-1:0] sink_addr,
    output logic [7:0]        sink_wdata,
    input  logic              sink_ack,
    input  logic [7:0]        sink_rdata,
    output logic [1:0]        train_pat,
    output logic [31:0]       lane_drive,
    output logic              done,
    output logic [1:0]        fail_code
);

    localparam int WAIT_MAX = (CR_WAIT > EQ_WAIT) ? CR_WAIT : EQ_WAIT;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_CAP, S_CAPCHK,
        S_CR_PAT, S_CR_LANE, S_CR_WAIT, S_CR_STAT, S_CR_EVAL,
        S_EQ_PAT, S_EQ_LANE, S_EQ_WAIT, S_EQ_STAT, S_EQ_EVAL,
        S_OFF, S_DONE
    } state_e;

    state_e            state;
    logic              fresh;
    logic [2:0]        lanes_q;
    drive_t            drive_q;
    logic [STAT_W-1:0] stat_q;
    logic [1:0]        pat_q;
    logic              done_q;
    fail_e             fail_q;
    logic [1:0]        prev_sw;
    logic              prev_vld;
    logic [2:0]        cr_tries;
    logic [2:0]        eq_iter;

    logic              x_go, x_we, x_fin, x_rd;
    logic [ADDR_W-1:0] x_base;
    logic [2:0]        x_len, x_idx;
    logic [7:0]        x_wdata, x_rdata;
    logic              t_go, t_fin;
    logic [WAIT_W-1:0] t_val;
    logic              cr_ok, eq_ok;
    drive_t            nxt;

    // transfer and wait launch for the current state
    always_comb begin
        x_go    = 1'b0;
        x_we    = 1'b0;
        x_base  = ADDR_W'(ADR_STATUS);
        x_len   = 3'(STAT_BYTES);
        x_wdata = 8'h00;
        t_go    = 1'b0;
        t_val   = WAIT_W'(CR_WAIT);
        unique case (state)
            S_CAP: begin
                x_go   = fresh;
                x_base = ADDR_W'(ADR_CAP_RATE);
                x_len  = 3'd2;
            end
            S_CR_PAT, S_EQ_PAT, S_OFF: begin
                x_go    = fresh;
                x_we    = 1'b1;
                x_base  = ADDR_W'(ADR_PATTERN);
                x_len   = 3'd1;
                x_wdata = {6'd0, pat_q};
            end
            S_CR_LANE, S_EQ_LANE: begin
                x_go    = fresh;
                x_we    = 1'b1;
                x_base  = ADDR_W'(ADR_LANE0);
                x_len   = lanes_q;
                x_wdata = drive_q;
            end
            S_CR_STAT, S_EQ_STAT: x_go = fresh;
            S_CR_WAIT: t_go = fresh;
            S_EQ_WAIT: begin
                t_go  = fresh;
                t_val = WAIT_W'(EQ_WAIT);
            end
            default: ;
        endcase
    end

    lt_xfer #(.ADDR_W(ADDR_W)) u_xfer (
        .clk(clk), .rst(rst), .go(x_go), .we(x_we), .base(x_base), .len(x_len),
        .wdata(x_wdata), .fin(x_fin), .rd_strobe(x_rd), .rd_idx(x_idx), .rd_data(x_rdata),
        .sink_req(sink_req), .sink_we(sink_we), .sink_addr(sink_addr),
        .sink_wdata(sink_wdata), .sink_ack(sink_ack), .sink_rdata(sink_rdata)
    );

    lt_wait #(.W(WAIT_W)) u_wait (
        .clk(clk), .rst(rst), .go(t_go), .val(t_val), .fin(t_fin)
    );

    lt_eval u_eval (
        .stat(stat_q), .lanes(lanes_q), .cr_ok(cr_ok), .eq_ok(eq_ok), .nxt(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            fresh    <= 1'b0;
            lanes_q  <= 3'd1;
            drive_q  <= '0;
            stat_q   <= '0;
            pat_q    <= 2'd0;
            done_q   <= 1'b0;
            fail_q   <= FAIL_NONE;
            prev_sw  <= 2'd0;
            prev_vld <= 1'b0;
            cr_tries <= '0;
            eq_iter  <= '0;
        end else begin
            fresh <= 1'b0;
            if (x_rd)
                stat_q[x_idx*8 +: 8] <= x_rdata;
            unique case (state)
                S_IDLE, S_DONE: if (start) begin
                    state   <= S_CAP;
                    fresh   <= 1'b1;
                    lanes_q <= clamp_lanes(lane_cnt);
                    done_q  <= 1'b0;
                    fail_q  <= FAIL_NONE;
                end
                S_CAP: if (x_fin) begin
                    state <= S_CAPCHK;
                    fresh <= 1'b1;
                end
                S_CAPCHK: begin
                    fresh <= 1'b1;
                    if (rate_ok(stat_q[7:0]) && (stat_q[12:8] != 5'd0)) begin
                        state    <= S_CR_PAT;
                        pat_q    <= 2'd1;
                        drive_q  <= '0;
                        prev_vld <= 1'b0;
                        cr_tries <= '0;
                    end else begin
                        state  <= S_DONE;
                        fail_q <= FAIL_CAPS;
                        done_q <= 1'b1;
                    end
                end
                S_CR_PAT, S_CR_LANE, S_CR_STAT, S_EQ_PAT, S_EQ_LANE, S_EQ_STAT: if (x_fin) begin
                    fresh <= 1'b1;
                    unique case (state)
                        S_CR_PAT:  state <= S_CR_LANE;
                        S_CR_LANE: state <= S_CR_WAIT;
                        S_CR_STAT: state <= S_CR_EVAL;
                        S_EQ_PAT:  state <= S_EQ_LANE;
                        S_EQ_LANE: state <= S_EQ_WAIT;
                        default:   state <= S_EQ_EVAL;
                    endcase
                end
                S_CR_WAIT: if (t_fin) begin
                    state <= S_CR_STAT;
                    fresh <= 1'b1;
                end
                S_EQ_WAIT: if (t_fin) begin
                    state <= S_EQ_STAT;
                    fresh <= 1'b1;
                end
                S_CR_EVAL: begin
                    fresh <= 1'b1;
                    if (cr_ok) begin
                        state   <= S_EQ_PAT;
                        pat_q   <= 2'd2;
                        eq_iter <= '0;
                    end else if (drive_q.sw_max) begin
                        state  <= S_OFF;
                        pat_q  <= 2'd0;
                        fail_q <= FAIL_CLKREC;
                    end else if (prev_vld && (drive_q.sw == prev_sw)
                                 && (cr_tries == 3'(CR_LIMIT - 1))) begin
                        state  <= S_OFF;
                        pat_q  <= 2'd0;
                        fail_q <= FAIL_CLKREC;
                    end else begin
                        state    <= S_CR_LANE;
                        cr_tries <= (prev_vld && (drive_q.sw == prev_sw)) ? cr_tries + 3'd1 : 3'd0;
                        prev_sw  <= drive_q.sw;
                        prev_vld <= 1'b1;
                        drive_q  <= nxt;
                    end
                end
                S_EQ_EVAL: begin
                    fresh <= 1'b1;
                    if (eq_ok) begin
                        state  <= S_OFF;
                        pat_q  <= 2'd0;
                        fail_q <= FAIL_NONE;
                    end else if (eq_iter == 3'(EQ_LIMIT - 1)) begin
                        state  <= S_OFF;
                        pat_q  <= 2'd0;
                        fail_q <= FAIL_EQUAL;
                    end else begin
                        state   <= S_EQ_LANE;
                        eq_iter <= eq_iter + 3'd1;
                        drive_q <= nxt;
                    end
                end
                S_OFF: if (x_fin) begin
                    state  <= S_DONE;
                    fresh  <= 1'b1;
                    done_q <= 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign train_pat  = pat_q;
    assign lane_drive = {4{drive_q}};
    assign done       = done_q;
    assign fail_code  = fail_q;

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !sink_req) // R11
        else $error("sink access while done");
    AST_CR_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (state inside {S_CR_LANE, S_CR_WAIT, S_CR_STAT, S_CR_EVAL}) |-> (train_pat == 2'd1)) // R3
        else $error("wrong pattern during clock recovery");
    AST_CR_REPEATS: assert property (@(posedge clk) disable iff (rst)
        cr_tries < 3'(CR_LIMIT)) // R7
        else $error("repeat count passed its limit");
    AST_EQ_ROUNDS: assert property (@(posedge clk) disable iff (rst)
        eq_iter < 3'(EQ_LIMIT)) // R10
        else $error("equalisation iteration count passed its limit");
    AST_SWING_FLAG: assert property (@(posedge clk) disable iff (rst)
        (lane_drive[1:0] == 2'd3) |-> lane_drive[2]) // R9
        else $error("max-swing flag missing");
    AST_PRE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (lane_drive[4:3] == 2'd3) |-> lane_drive[5]) // R9
        else $error("max-pre-emphasis flag missing");
    AST_SAME_LANES: assert property (@(posedge clk) disable iff (rst)
        (lane_drive[15:8] == lane_drive[7:0]) && (lane_drive[31:24] == lane_drive[7:0])) // R8
        else $error("lane settings differ");

endmodule

// File: tb/lt_train_ctrl_tb.sv
module lt_train_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  lane_cnt = 3'd1;
    logic        sink_req, sink_we;
    logic [19:0] sink_addr;
    logic [7:0]  sink_wdata;
    logic        sink_ack = 1'b0;
    logic [7:0]  sink_rdata = 8'h00;
    logic [1:0]  train_pat;
    logic [31:0] lane_drive;
    logic        done;
    logic [1:0]  fail_code;

    always #2.5 clk = ~clk;

    lt_train_ctrl #(.ADDR_W(20), .CR_WAIT(20), .EQ_WAIT(8)) u_dut (
        .clk(clk), .rst(rst), .start(start), .lane_cnt(lane_cnt),
        .sink_req(sink_req), .sink_we(sink_we), .sink_addr(sink_addr),
        .sink_wdata(sink_wdata), .sink_ack(sink_ack), .sink_rdata(sink_rdata),
        .train_pat(train_pat), .lane_drive(lane_drive), .done(done), .fail_code(fail_code)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // sink model configuration
    logic [7:0] rate_v = 8'h0A;
    logic [7:0] lcap_v = 8'h04;
    int need_sw = 0, need_pre = 0, bad_lane = -1, cur_lanes = 1;
    bit eq_never = 0, no_align = 0, step_mode = 0;
    int step_cap = 0;
    int req_sw [4];
    int req_pre [4];
    logic [7:0] rx [4];
    int n_stat = 0, n_lane_wr = 0, n_pat = 0;
    int pat_log [4];
    int pat_at_read1 = -1;

    function automatic bit lane_cr(input int i);
        return (int'(rx[i][1:0]) >= need_sw) && (i != bad_lane);
    endfunction
    function automatic bit lane_eq(input int i);
        return lane_cr(i) && (int'(rx[i][4:3]) >= need_pre) && !eq_never;
    endfunction
    function automatic logic [3:0] nib(input int i);
        return {1'b0, lane_eq(i), lane_eq(i), lane_cr(i)};
    endfunction
    function automatic logic [3:0] rq(input int i);
        int s;
        s = step_mode ? ((int'(rx[0][1:0]) + 1 > step_cap) ? step_cap : int'(rx[0][1:0]) + 1) : req_sw[i];
        return {2'(req_pre[i]), 2'(s)};
    endfunction

    function automatic logic [7:0] rd_byte(input int a);
        bit al;
        case (a)
            'h001: return rate_v;
            'h002: return lcap_v;
            'h202: return {nib(1), nib(0)};
            'h203: return {nib(3), nib(2)};
            'h204: begin
                al = !no_align;
                for (int i = 0; i < cur_lanes; i++) if (!lane_eq(i)) al = 0;
                return {7'd0, al};
            end
            'h206: return {rq(1), rq(0)};
            'h207: return {rq(3), rq(2)};
            default: return 8'h00;
        endcase
    endfunction

    always @(negedge clk) begin
        if (sink_ack) sink_ack = 1'b0;
        else if (sink_req) begin
            if (sink_we) begin
                if (sink_addr == 20'h102) begin
                    if (n_pat < 4) pat_log[n_pat] = int'(sink_wdata);
                    n_pat++;
                end else if (sink_addr >= 20'h103 && sink_addr <= 20'h106) begin
                    rx[sink_addr - 20'h103] = sink_wdata;
                    n_lane_wr++;
                end
            end else begin
                if (sink_addr == 20'h202) begin
                    n_stat++;
                    if (n_stat == 1) pat_at_read1 = int'(train_pat);
                end
                sink_rdata = rd_byte(int'(sink_addr));
            end
            sink_ack = 1'b1;
        end
    end

    typedef struct {
        string name;
        int fail, drive, reads, lane_wr, npat, pat0, pat1;
    } exp_t;
    exp_t exp_q [$];

    // monitor: compare outcome when the design reports done
    bit seen = 0;
    always @(negedge clk) begin
        if (!done) seen = 0;
        else if (!seen && exp_q.size() != 0) begin
            exp_t e;
            seen = 1;
            e = exp_q.pop_front();
            chk({e.name, " R11 fail_code"}, int'(fail_code), e.fail);
            chk({e.name, " R8 lane0 drive"}, int'(lane_drive[7:0]), e.drive);
            chk({e.name, " R8 lanes uniform"}, int'(lane_drive), {4{e.drive[7:0]}});
            chk({e.name, " R4 status reads"}, n_stat, e.reads);
            chk({e.name, " R4 lane writes"}, n_lane_wr, e.lane_wr);
            chk({e.name, " R11 pattern writes"}, n_pat, e.npat);
            if (e.npat > 0) chk({e.name, " R3 first pattern"}, pat_log[0], e.pat0);
            if (e.npat > 1) chk({e.name, " R10 second pattern"}, pat_log[1], e.pat1);
            if (e.npat > 0) chk({e.name, " R11 pattern off last"}, pat_log[(e.npat > 4 ? 4 : e.npat) - 1], 0);
            chk({e.name, " R11 local pattern off"}, int'(train_pat), 0);
        end
    end

    task automatic run_case(input exp_t e, input int lanes);
        n_stat = 0; n_lane_wr = 0; n_pat = 0; pat_at_read1 = -1;
        for (int i = 0; i < 4; i++) rx[i] = 8'h00;
        cur_lanes = lanes;
        lane_cnt  = 3'(lanes);
        exp_q.push_back(e);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (exp_q.size() != 0 || !seen) @(negedge clk);
    endtask

    task automatic set_sink(input int nsw, input int npre, input int bad, input bit eqn, input bit nal);
        need_sw = nsw; need_pre = npre; bad_lane = bad; eq_never = eqn; no_align = nal;
        step_mode = 0; rate_v = 8'h0A; lcap_v = 8'h04;
        for (int i = 0; i < 4; i++) begin req_sw[i] = 0; req_pre[i] = 0; end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", int'(done), 0);
        chk("R1 pattern", int'(train_pat), 0);
        chk("R1 drive", int'(lane_drive), 0);
        chk("R1 fail_code", int'(fail_code), 0);
        chk("R1 request", int'(sink_req), 0);

        // pass, two lanes, max taken across lanes
        set_sink(1, 1, -1, 0, 0);
        req_sw[0] = 1; req_sw[1] = 2; req_pre[0] = 1; req_pre[1] = 0;
        run_case('{"two-lane pass", 0, 'h0A, 3, 6, 3, 1, 2}, 2);
        chk("R3 pattern shown during first status read", pat_at_read1, 1);
        repeat (10) @(negedge clk);
        chk("R11 done held", int'(done), 1);

        // same sink, one lane: lane 1 request and status ignored (R5)
        run_case('{"one-lane pass R5", 0, 'h09, 3, 3, 3, 1, 2}, 1);

        // CR repeat limit with constant swing
        set_sink(0, 0, 0, 0, 0);
        run_case('{"repeat limit R7", 2, 'h00, 6, 6, 2, 1, 0}, 1);

        // max swing stop
        set_sink(0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) req_sw[i] = 3;
        run_case('{"max swing R6 R9", 2, 'h07, 2, 8, 2, 1, 0}, 4);

        // EQ never passes; request in upper byte with pre-emphasis 3
        set_sink(0, 0, -1, 1, 0);
        req_sw[1] = 1; req_pre[2] = 3;
        run_case('{"eq limit R10 R9", 3, 'h39, 6, 24, 3, 1, 2}, 4);

        // alignment missing
        set_sink(0, 0, -1, 0, 1);
        run_case('{"no align R10", 3, 'h00, 6, 12, 3, 1, 2}, 2);

        // capability refusals
        set_sink(0, 0, -1, 0, 0);
        rate_v = 8'h14;
        run_case('{"bad rate R2", 1, 'h00, 0, 0, 0, 0, 0}, 1);
        set_sink(0, 0, -1, 0, 0);
        lcap_v = 8'hE0;
        run_case('{"zero lane cap R2", 1, 'h00, 0, 0, 0, 0, 0}, 1);
        set_sink(0, 0, -1, 0, 0);
        rate_v = 8'h06;
        run_case('{"low rate R2", 0, 'h00, 2, 2, 3, 1, 2}, 1);

        // repeat count cleared by swing change
        set_sink(0, 0, 0, 0, 0);
        step_mode = 1; step_cap = 2;
        run_case('{"repeat reset R7", 2, 'h02, 8, 8, 2, 1, 0}, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule